// File: doc/BRIEF.md
# Chained-Handshake Job Control Register File

This block is the software-facing control register file of a pipelined accelerator. An AXI4-Lite slave decodes a control word and a set of 32-bit job arguments: a direction flag, a chaining flag, four initial-vector words, a word count, and a source address and a destination address, each split into two halves. The control word separates two handshakes. The input side pairs a start request with the datapath's ready signal. The output side pairs the datapath's completion events with a continue acknowledgement that clears itself.

Software sets start. The request stays raised on `dp_start` until the datapath answers with `dp_ready`. That start/ready handshake launches a job and copies every argument into a job snapshot, which the datapath reads. Software may then rewrite the arguments and queue the next start while earlier jobs are still running. Completions are counted, so several back-to-back done events are never merged. The done bit stays set until software has acknowledged every one of them with continue. The block has no interrupt logic.

Top module: `chain_ctrl_regs`

## Requirements
- R1: After reset, every argument reads zero, the control word reads 0x04 (only idle set), `dp_start` and `job_valid` are low, and no AXI response is pending.
- R2: The argument registers sit at these byte offsets: direction flag 0x010, IV word 3 0x018, IV word 2 0x020, IV word 1 0x028, IV word 0 0x030, word count 0x038, source low 0x040, source high 0x044, destination low 0x048, destination high 0x04C, chaining flag 0x050. Each reads back what was written, with byte lane n written only when write strobe bit n is set. The two flags keep bit 0 only and read zero in bits 31:1.
- R3: Any other offset except 0x000 reads zero, and writes to it change nothing. Every write response and every read response is OKAY (2'b00).
- R4: The control word is at offset 0x000, with start in bit 0, done in bit 1, idle in bit 2, ready in bit 3 and continue in bit 4. Writing 1 to bit 0 sets start, and `dp_start` follows it. Writing 0 to bit 0 has no effect. Start stays set while `dp_ready` is low.
- R5: A clock edge with `dp_start` and `dp_ready` both high is a handshake. At that edge start clears, unless the same edge also writes start. In the next cycle `job_valid` is high for one cycle and the job outputs hold the argument values from that edge: `job_iv` = {IV3, IV2, IV1, IV0}, `job_src` = {high, low}, `job_dst` = {high, low}. Later argument writes do not alter the job outputs until the next handshake.
- R6: Each edge with `dp_done` high adds one to an unacknowledged-completion count. Each write of 1 to control bit 4 takes one from it, if it is non-zero. When both happen on the same edge, the count goes up only if it was zero; otherwise it is unchanged. The done bit reads 1 exactly while the count is non-zero.
- R7: The continue bit reads 1 only in the cycle that follows its write, and 0 after that.
- R8: The completion count saturates at MAX_JOBS. A continue written while the count is zero leaves it at zero.
- R9: Idle reads 1 exactly when start is clear, no completion is unacknowledged, and no launched job is waiting for its done event. The in-flight job count uses the same saturation rule as the completion count.
- R10: The ready bit reads the live value of `dp_ready`.
- R11: A write is accepted when address and data are valid together and no write response is pending. `s_bvalid` holds until `s_bready`. `s_rvalid` holds, with `s_rdata` stable, until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| dp_start | output | 1 | Pending job request to the datapath |
| dp_ready | input | 1 | Datapath can take a job |
| dp_done | input | 1 | One-cycle completion event from the datapath |
| job_valid | output | 1 | One-cycle pulse after a launch |
| job_encrypt | output | 1 | Latched direction flag |
| job_chain | output | 1 | Latched chaining flag |
| job_iv | output | 128 | Latched initial vector {IV3, IV2, IV1, IV0} |
| job_words | output | 32 | Latched word count |
| job_src | output | 64 | Latched source address |
| job_dst | output | 64 | Latched destination address |

## Verification
The bench builds the block with ADDR_W = 10 and MAX_JOBS = 3. The 10-bit address space lets a read sweep cover all 256 word addresses and compare each one with a value computed from the offset map. That sweep catches any aliasing or stray decode. A limit of 3 lets a burst of five completions drive the counter into saturation, and unwinds it one continue at a time. That covers the saturated, underflow and simultaneous done-and-continue corners within a few dozen cycles.

// File: rtl/chain_ctrl_pkg.sv
package chain_ctrl_pkg;

   // control word bit positions
   localparam int CB_START = 0;
   localparam int CB_DONE  = 1;
   localparam int CB_IDLE  = 2;
   localparam int CB_READY = 3;
   localparam int CB_CONT  = 4;
   localparam int CTRL_BITS = 5;

   localparam int CTRL_OFS = 'h000;

   // argument slot indices
   localparam int AI_DIR    = 0;
   localparam int AI_IV3    = 1;
   localparam int AI_IV2    = 2;
   localparam int AI_IV1    = 3;
   localparam int AI_IV0    = 4;
   localparam int AI_WORDS  = 5;
   localparam int AI_SRC_LO = 6;
   localparam int AI_SRC_HI = 7;
   localparam int AI_DST_LO = 8;
   localparam int AI_DST_HI = 9;
   localparam int AI_CHAIN  = 10;
   localparam int NUM_ARGS  = 11;

   function automatic int arg_offset(input int idx);
      case (idx)
         AI_DIR:    return 'h010;
         AI_IV3:    return 'h018;
         AI_IV2:    return 'h020;
         AI_IV1:    return 'h028;
         AI_IV0:    return 'h030;
         AI_WORDS:  return 'h038;
         AI_SRC_LO: return 'h040;
         AI_SRC_HI: return 'h044;
         AI_DST_LO: return 'h048;
         AI_DST_HI: return 'h04C;
         AI_CHAIN:  return 'h050;
         default:   return 'h000;
      endcase
   endfunction

   function automatic logic [31:0] arg_mask(input int idx);
      return (idx == AI_DIR || idx == AI_CHAIN) ? 32'h0000_0001 : 32'hFFFF_FFFF;
   endfunction

   typedef struct packed {
      logic         encrypt;
      logic         chain;
      logic [127:0] iv;
      logic [31:0]  words;
      logic [63:0]  src;
      logic [63:0]  dst;
   } job_t;

endpackage

// File: rtl/chain_sat_counter.sv
module chain_sat_counter #(
   parameter  int LIMIT = 4,
   localparam int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] count
);

   logic do_dec;
   assign do_dec = dec && (count != '0);

   if (LIMIT < 1) begin : g_bad_limit
      $error("chain_sat_counter: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q <= 1'b0;
         else if (inc)    flag_q <= 1'b1;
         else if (do_dec) flag_q <= 1'b0;
      end
      assign count = flag_q;
   end else begin : g_count
      localparam logic [W-1:0] TOP = W'(LIMIT);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (inc && !do_dec && cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
         else if (do_dec && !inc)
            cnt_q <= cnt_q - 1'b1;
      end
      assign count = cnt_q;
   end

endmodule

// File: rtl/chain_axil_port.sv
module chain_axil_port #(
   parameter  int ADDR_W = 12,
   parameter  int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [STRB_W-1:0] wr_strb,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data
);

   logic              bvalid_q;
   logic              rvalid_q;
   logic [DATA_W-1:0] rdata_q;

   // address and data are taken together, one response at a time
   assign wr_en     = s_awvalid && s_wvalid && !bvalid_q;
   assign s_awready = wr_en;
   assign s_wready  = wr_en;
   assign wr_addr   = s_awaddr;
   assign wr_data   = s_wdata;
   assign wr_strb   = s_wstrb;

   assign rd_en     = s_arvalid && !rvalid_q;
   assign s_arready = rd_en;
   assign rd_addr   = s_araddr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bvalid_q <= 1'b0;
      else if (wr_en)    bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_en) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_data;
      end else if (s_rready) begin
         rvalid_q <= 1'b0;
      end
   end

   assign s_bvalid = bvalid_q;
   assign s_bresp  = 2'b00;
   assign s_rvalid = rvalid_q;
   assign s_rdata  = rdata_q;
   assign s_rresp  = 2'b00;

endmodule

// File: rtl/chain_arg_bank.sv
module chain_arg_bank
   import chain_ctrl_pkg::*;
#(
   parameter  int WA_W   = 10,
   parameter  int DATA_W = 32,
   localparam int STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WA_W-1:0]   wr_waddr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [STRB_W-1:0] wr_strb,
   input  logic [WA_W-1:0]   rd_waddr,
   output logic [DATA_W-1:0] rd_val,
   input  logic              launch,
   output job_t              job
);

   logic [NUM_ARGS-1:0][DATA_W-1:0] arg_w;
   logic [NUM_ARGS-1:0]             rd_sel;

   for (genvar i = 0; i < NUM_ARGS; i++) begin : g_arg
      localparam logic [WA_W-1:0]   WA   = WA_W'(arg_offset(i) >> 2);
      localparam logic [DATA_W-1:0] MASK = DATA_W'(arg_mask(i));
      logic              hit_w;
      logic [DATA_W-1:0] val_q;

      assign hit_w     = wr_en && (wr_waddr == WA);
      assign rd_sel[i] = (rd_waddr == WA);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (hit_w) begin
            for (int b = 0; b < STRB_W; b++) begin
               if (wr_strb[b]) val_q[8*b +: 8] <= wr_data[8*b +: 8] & MASK[8*b +: 8];
            end
         end
      end
      assign arg_w[i] = val_q;
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_ARGS; i++) begin
         if (rd_sel[i]) rd_val = arg_w[i];
      end
   end

   // snapshot of the arguments taken at the start/ready handshake
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         job <= '0;
      end else if (launch) begin
         job.encrypt <= arg_w[AI_DIR][0];
         job.chain   <= arg_w[AI_CHAIN][0];
         job.iv      <= {arg_w[AI_IV3], arg_w[AI_IV2], arg_w[AI_IV1], arg_w[AI_IV0]};
         job.words   <= arg_w[AI_WORDS];
         job.src     <= {arg_w[AI_SRC_HI], arg_w[AI_SRC_LO]};
         job.dst     <= {arg_w[AI_DST_HI], arg_w[AI_DST_LO]};
      end
   end

endmodule

// File: rtl/chain_sync_ctrl.sv
module chain_sync_ctrl
   import chain_ctrl_pkg::*;
#(
   parameter  int MAX_JOBS = 4,
   localparam int CNT_W    = $clog2(MAX_JOBS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr,
   input  logic                 set_start,
   input  logic                 set_cont,
   input  logic                 dp_ready,
   input  logic                 dp_done,
   output logic                 dp_start,
   output logic                 launch,
   output logic [CTRL_BITS-1:0] ctrl_bits,
   output logic [CNT_W-1:0]     pend_cnt,
   output logic                 cont_q
);

   logic             start_q;
   logic             ack;
   logic [CNT_W-1:0] fly_cnt;
   logic             idle;

   assign launch = start_q && dp_ready;
   assign ack    = ctrl_wr && set_cont;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         cont_q  <= 1'b0;
      end else begin
         start_q <= (start_q && !dp_ready) || (ctrl_wr && set_start);
         cont_q  <= ack;
      end
   end

   // completions not yet acknowledged by software
   chain_sat_counter #(.LIMIT(MAX_JOBS)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (dp_done),
      .dec   (ack),
      .count (pend_cnt)
   );

   // launched jobs still waiting for their completion event
   chain_sat_counter #(.LIMIT(MAX_JOBS)) u_fly (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (launch),
      .dec   (dp_done),
      .count (fly_cnt)
   );

   assign idle     = !start_q && (pend_cnt == '0) && (fly_cnt == '0);
   assign dp_start = start_q;

   always_comb begin
      ctrl_bits           = '0;
      ctrl_bits[CB_START] = start_q;
      ctrl_bits[CB_DONE]  = (pend_cnt != '0);
      ctrl_bits[CB_IDLE]  = idle;
      ctrl_bits[CB_READY] = dp_ready;
      ctrl_bits[CB_CONT]  = cont_q;
   end

endmodule

// File: rtl/chain_ctrl_regs.sv
module chain_ctrl_regs
   import chain_ctrl_pkg::*;
#(
   parameter  int ADDR_W   = 12,
   parameter  int DATA_W   = 32,
   parameter  int MAX_JOBS = 4,
   localparam int STRB_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic [STRB_W-1:0] s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              dp_start,
   input  logic              dp_ready,
   input  logic              dp_done,
   output logic              job_valid,
   output logic              job_encrypt,
   output logic              job_chain,
   output logic [127:0]      job_iv,
   output logic [31:0]       job_words,
   output logic [63:0]       job_src,
   output logic [63:0]       job_dst
);

   localparam int WA_W  = ADDR_W - 2;
   localparam int CNT_W = $clog2(MAX_JOBS + 1);
   localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_OFS >> 2);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("chain_ctrl_regs: DATA_W must be 32");
   end
   if (ADDR_W < 7) begin : g_bad_addr_w
      $error("chain_ctrl_regs: ADDR_W too small for the register map");
   end
   if (MAX_JOBS < 1) begin : g_bad_jobs
      $error("chain_ctrl_regs: MAX_JOBS must be at least 1");
   end

   logic                 wr_en;
   logic [ADDR_W-1:0]    wr_addr;
   logic [DATA_W-1:0]    wr_data;
   logic [STRB_W-1:0]    wr_strb;
   logic                 rd_en;
   logic [ADDR_W-1:0]    rd_addr;
   logic [DATA_W-1:0]    rd_data;
   logic [DATA_W-1:0]    arg_rd;
   logic                 ctrl_wr;
   logic                 launch;
   logic [CTRL_BITS-1:0] ctrl_bits;
   logic [CNT_W-1:0]     pend_cnt;
   logic                 cont_q;
   logic                 job_valid_q;
   job_t                 job;
   logic                 unused_lo;

   chain_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_awaddr  (s_awaddr),
      .s_awvalid (s_awvalid),
      .s_awready (s_awready),
      .s_wdata   (s_wdata),
      .s_wstrb   (s_wstrb),
      .s_wvalid  (s_wvalid),
      .s_wready  (s_wready),
      .s_bresp   (s_bresp),
      .s_bvalid  (s_bvalid),
      .s_bready  (s_bready),
      .s_araddr  (s_araddr),
      .s_arvalid (s_arvalid),
      .s_arready (s_arready),
      .s_rdata   (s_rdata),
      .s_rresp   (s_rresp),
      .s_rvalid  (s_rvalid),
      .s_rready  (s_rready),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_strb   (wr_strb),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   chain_arg_bank #(.WA_W(WA_W), .DATA_W(DATA_W)) u_args (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_waddr (wr_addr[ADDR_W-1:2]),
      .wr_data  (wr_data),
      .wr_strb  (wr_strb),
      .rd_waddr (rd_addr[ADDR_W-1:2]),
      .rd_val   (arg_rd),
      .launch   (launch),
      .job      (job)
   );

   assign ctrl_wr = wr_en && (wr_addr[ADDR_W-1:2] == CTRL_WA) && wr_strb[0];

   chain_sync_ctrl #(.MAX_JOBS(MAX_JOBS)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .set_start (wr_data[CB_START]),
      .set_cont  (wr_data[CB_CONT]),
      .dp_ready  (dp_ready),
      .dp_done   (dp_done),
      .dp_start  (dp_start),
      .launch    (launch),
      .ctrl_bits (ctrl_bits),
      .pend_cnt  (pend_cnt),
      .cont_q    (cont_q)
   );

   assign rd_data = (rd_addr[ADDR_W-1:2] == CTRL_WA) ? DATA_W'(ctrl_bits) : arg_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) job_valid_q <= 1'b0;
      else        job_valid_q <= launch;
   end

   assign job_valid   = job_valid_q;
   assign job_encrypt = job.encrypt;
   assign job_chain   = job.chain;
   assign job_iv      = job.iv;
   assign job_words   = job.words;
   assign job_src     = job.src;
   assign job_dst     = job.dst;

   assign unused_lo = ^{wr_addr[1:0], rd_addr[1:0], rd_en};

endmodule

// File: rtl/chain_ctrl_regs_chk.sv
module chain_ctrl_regs_chk #(
   parameter  int MAX_JOBS = 4,
   parameter  int DATA_W   = 32,
   localparam int CNT_W    = $clog2(MAX_JOBS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dp_start,
   input logic              dp_ready,
   input logic              dp_done,
   input logic              job_valid,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic [DATA_W-1:0] s_wdata,
   input logic              ctrl_wr,
   input logic              cont_q,
   input logic [CNT_W-1:0]  pend_cnt,
   input logic [4:0]        ctrl_bits
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_JOBS);

   AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_start && !dp_ready) |=> dp_start);  // R4

   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_start && dp_ready && !(ctrl_wr && s_wdata[0])) |=> !dp_start);  // R5

   AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_start && dp_ready) |=> job_valid);  // R5

   AST_NO_STRAY_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(dp_start && dp_ready) |=> !job_valid);  // R5

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_bits[1] && !(ctrl_wr && s_wdata[4])) |=> ctrl_bits[1]);  // R6

   AST_CONT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cont_q |=> !cont_q);  // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_cnt == TOP && dp_done && !(ctrl_wr && s_wdata[4])) |=> pend_cnt == TOP);  // R8

   AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_bits[2] |-> (!dp_start && !ctrl_bits[1]));  // R9

   AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> s_bvalid);  // R11

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));  // R11

endmodule

bind chain_ctrl_regs chain_ctrl_regs_chk #(.MAX_JOBS(MAX_JOBS), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dp_start  (dp_start),
   .dp_ready  (dp_ready),
   .dp_done   (dp_done),
   .job_valid (job_valid),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .s_rvalid  (s_rvalid),
   .s_rready  (s_rready),
   .s_rdata   (s_rdata),
   .s_wdata   (s_wdata),
   .ctrl_wr   (ctrl_wr),
   .cont_q    (cont_q),
   .pend_cnt  (pend_cnt),
   .ctrl_bits (ctrl_bits)
);

// File: tb/chain_ctrl_regs_tb.sv
`timescale 1ns/1ps
module chain_ctrl_regs_tb;

   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1;
   logic          arvalid = 1'b0, rready = 1'b1;
   logic [31:0]   wdata = '0;
   logic [3:0]    wstrb = '0;
   logic          awready, wready, bvalid, arready, rvalid;
   logic [1:0]    bresp, rresp;
   logic [31:0]   rdata;
   logic          dp_start, dp_ready = 1'b0, dp_done = 1'b0;
   logic          job_valid, job_encrypt, job_chain;
   logic [127:0]  job_iv;
   logic [31:0]   job_words;
   logic [63:0]   job_src, job_dst;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_arg [11];
   bit done_flag = 0;

   always #4 clk = ~clk;

   chain_ctrl_regs #(.ADDR_W(AW), .DATA_W(32), .MAX_JOBS(3)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .dp_start(dp_start), .dp_ready(dp_ready), .dp_done(dp_done),
      .job_valid(job_valid), .job_encrypt(job_encrypt), .job_chain(job_chain),
      .job_iv(job_iv), .job_words(job_words), .job_src(job_src), .job_dst(job_dst)
   );

   function automatic int ofs(input int i);
      case (i)
         0: return 'h010;  1: return 'h018;  2: return 'h020;  3: return 'h028;
         4: return 'h030;  5: return 'h038;  6: return 'h040;  7: return 'h044;
         8: return 'h048;  9: return 'h04C;  default: return 'h050;
      endcase
   endfunction

   function automatic logic [31:0] model_read(input int byte_ofs, input logic [31:0] ctrl);
      if (byte_ofs == 0) return ctrl;
      for (int i = 0; i < 11; i++) if (ofs(i) == byte_ofs) return exp_arg[i];
      return 32'h0;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic axi_write(input int a, input logic [31:0] d, input logic [3:0] s,
                            input logic with_done);
      @(negedge clk);
      awaddr = AW'(a); wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
      dp_done = with_done;
      #1;
      while (!awready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      awvalid = 1'b0; wvalid = 1'b0; dp_done = 1'b0;
      chk("R3", {bvalid, bresp}, 3'b100);
   endtask

   task automatic axi_read(input int a, output logic [31:0] d);
      @(negedge clk);
      araddr = AW'(a); arvalid = 1'b1;
      #1;
      while (!arready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      arvalid = 1'b0;
      d = rdata;
      chk("R3", {rvalid, rresp}, 3'b100);
   endtask

   task automatic read_chk(input string req, input int a, input logic [31:0] exp);
      logic [31:0] d;
      axi_read(a, d);
      chk(req, d, exp);
   endtask

   task automatic handshake();
      @(negedge clk); dp_ready = 1'b1;
      @(posedge clk); #1; dp_ready = 1'b0;
      chk("R5", dp_start, 1'b0);
      chk("R5", job_valid, 1'b1);
      chk("R5", job_iv, {exp_arg[1], exp_arg[2], exp_arg[3], exp_arg[4]});
      chk("R5", job_src, {exp_arg[7], exp_arg[6]});
      chk("R5", job_dst, {exp_arg[9], exp_arg[8]});
      chk("R5", job_words, exp_arg[5]);
      chk("R5", {job_encrypt, job_chain}, {exp_arg[0][0], exp_arg[10][0]});
      @(posedge clk); #1;
      chk("R5", job_valid, 1'b0);
   endtask

   task automatic done_pulses(input int n);
      @(negedge clk); dp_done = 1'b1;
      repeat (n) @(negedge clk);
      dp_done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 11; i++) exp_arg[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;

      // R1: reset state
      chk("R1", {dp_start, job_valid, bvalid, rvalid}, 4'b0000);
      chk("R1", job_iv, 128'h0);
      read_chk("R1", 'h000, 32'h04);
      for (int i = 0; i < 11; i++) read_chk("R1", ofs(i), 32'h0);

      // R2: write and read back every argument
      for (int i = 0; i < 11; i++) begin
         logic [31:0] v;
         v = (32'h1357_9BDF * (i + 1)) ^ 32'hA5A5_0000;
         axi_write(ofs(i), v, 4'hF, 1'b0);
         exp_arg[i] = (i == 0 || i == 10) ? {31'h0, v[0]} : v;
      end
      axi_write(ofs(0), 32'hFFFF_FFFF, 4'hF, 1'b0);  exp_arg[0] = 32'h1;
      axi_write(ofs(10), 32'hFFFF_FFFE, 4'hF, 1'b0); exp_arg[10] = 32'h0;
      for (int i = 0; i < 11; i++) read_chk("R2", ofs(i), exp_arg[i]);
      // R2: byte strobes, lanes 0 and 2 only
      axi_write(ofs(6), 32'hFFFF_FFFF, 4'b0101, 1'b0);
      exp_arg[6] = (exp_arg[6] & 32'hFF00_FF00) | 32'h00FF_00FF;
      read_chk("R2", ofs(6), exp_arg[6]);

      // R3: writes to unmapped offsets, then sweep every word address
      axi_write('h004, 32'hFFFF_FFFF, 4'hF, 1'b0);
      axi_write('h014, 32'hFFFF_FFFF, 4'hF, 1'b0);
      axi_write('h054, 32'hFFFF_FFFF, 4'hF, 1'b0);
      axi_write('h3FC, 32'hFFFF_FFFF, 4'hF, 1'b0);
      for (int w = 0; w < 256; w++) read_chk("R3", w * 4, model_read(w * 4, 32'h04));

      // R4: writing 0 to start does nothing, writing 1 sets it and holds
      axi_write('h000, 32'h0, 4'hF, 1'b0);
      read_chk("R4", 'h000, 32'h04);
      chk("R4", dp_start, 1'b0);
      axi_write('h000, 32'h1, 4'hF, 1'b0);
      chk("R4", dp_start, 1'b1);
      repeat (4) @(posedge clk);
      #1 chk("R4", dp_start, 1'b1);
      read_chk("R4", 'h000, 32'h01);

      // R5: launch, then argument rewrites do not touch the snapshot
      handshake();
      read_chk("R9", 'h000, 32'h00);
      axi_write(ofs(4), 32'hDEAD_BEEF, 4'hF, 1'b0);
      chk("R5", job_iv, {exp_arg[1], exp_arg[2], exp_arg[3], exp_arg[4]});
      exp_arg[4] = 32'hDEAD_BEEF;

      // R6 / R7: one completion, then acknowledge
      done_pulses(1);
      read_chk("R6", 'h000, 32'h02);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R7", 'h000, 32'h14);
      read_chk("R7", 'h000, 32'h04);

      // R6: two queued jobs, back-to-back completions
      axi_write('h000, 32'h1, 4'hF, 1'b0);
      handshake();
      axi_write('h000, 32'h1, 4'hF, 1'b0);
      handshake();
      read_chk("R9", 'h000, 32'h00);
      done_pulses(2);
      read_chk("R6", 'h000, 32'h02);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R6", 'h000, 32'h12);
      read_chk("R6", 'h000, 32'h02);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R6", 'h000, 32'h14);
      read_chk("R9", 'h000, 32'h04);

      // R8: five completions saturate at 3
      done_pulses(5);
      read_chk("R8", 'h000, 32'h02);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R8", 'h000, 32'h12);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R8", 'h000, 32'h12);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R8", 'h000, 32'h14);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R8", 'h000, 32'h14);
      done_pulses(1);
      read_chk("R8", 'h000, 32'h02);

      // R6: completion and continue on the same edge with count 1
      axi_write('h000, 32'h10, 4'hF, 1'b1);
      read_chk("R6", 'h000, 32'h12);
      axi_write('h000, 32'h10, 4'hF, 1'b0);
      read_chk("R6", 'h000, 32'h14);

      // R10: ready bit follows the datapath input
      @(negedge clk) dp_ready = 1'b1;
      read_chk("R10", 'h000, 32'h0C);
      @(negedge clk) dp_ready = 1'b0;
      read_chk("R10", 'h000, 32'h04);

      // R11: write response held while bready is low
      @(negedge clk);
      bready = 1'b0; awaddr = AW'('h008); wdata = 32'h5; wstrb = 4'hF;
      awvalid = 1'b1; wvalid = 1'b1;
      @(posedge clk); #1; awvalid = 1'b0; wvalid = 1'b0;
      repeat (3) @(posedge clk);
      #1 chk("R11", {bvalid, bresp}, 3'b100);
      @(negedge clk) bready = 1'b1;
      @(posedge clk); #1 chk("R11", bvalid, 1'b0);

      // R11: read data held while rready is low
      @(negedge clk);
      rready = 1'b0; araddr = AW'(ofs(5)); arvalid = 1'b1;
      @(posedge clk); #1; arvalid = 1'b0;
      d = rdata;
      repeat (3) @(posedge clk);
      #1 chk("R11", {rvalid, rdata}, {1'b1, exp_arg[5]});
      chk("R11", d, exp_arg[5]);
      @(negedge clk) rready = 1'b1;
      @(posedge clk); #1 chk("R11", rvalid, 1'b0);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule